// File: doc/BRIEF.md
# Flash hardware-mode status and write-enable sequencer

This unit sits inside a serial flash controller and runs two fixed flash commands without software having to build a frame by hand. While the controller is out of software mode, a register write that sets one of two command bits makes the unit issue a command to the selected flash bank through the shared SPI shifter. The first command reads the flash status byte. The second sets the flash write-enable latch. The two commands use a request/acknowledge/done handshake with the shifter.

The result of a status read is folded into the controller status register. The raw flash byte is stored there, and the write-enable-latch bit of that byte is kept as a per-bank write-mode flag. The status register also holds a transfer-finished flag, a write-complete flag and two error flags. Each of these flags is set by its hardware event and cleared by writing it as zero. Two enables gate an interrupt output. Write-complete and error events come from the page-programming side of the controller, which lies outside this unit.

Top module: `fhs_top`

## Requirements
- R1: After reset, every register reads zero. `shf_req` and `irq` are low.
- R2: A write to control 2 (address 1) with bit 10 set launches a status read. `shf_req` rises on the next cycle with opcode 0x05, `shf_rx_bytes` = 1 and `shf_bank` equal to bits [13:12] of the write. The request and its fields stay steady until `shf_ack` is seen.
- R3: A write to control 2 with bit 11 set launches a write-enable. The request carries opcode 0x06, `shf_rx_bytes` = 0 and the bank from bits [13:12].
- R4: When bits 10 and 11 are both set in one write, only the status read is issued.
- R5: On `shf_done` of a status read, status bits [7:0] take `shf_rxdata`. In that byte, bit 0 is write-in-progress and bit 1 is write-enable-latch. A write-enable completion leaves bits [7:0] unchanged.
- R6: Status bit 12+n is the write-mode flag of bank n. Each completed status read of bank n loads that flag from bit 1 of the flash byte. The flags of other banks keep their values.
- R7: Completion of either command sets transfer-finished at status bit 8. Nothing else sets it.
- R8: A `wc_evt` pulse sets write-complete at status bit 9 and clears the write-mode flag of bank `wc_bank`. `err_evt[0]` sets status bit 10 and `err_evt[1]` sets status bit 11.
- R9: A write to the status register (address 2) clears each of bits 8 to 11 whose written value is 0. A written 1 leaves the bit unchanged. When a hardware set and a clear fall in the same cycle, the set wins.
- R10: While control 1 (address 0) bit 28, the software-mode bit, is 1, the command bits are ignored and no request is made.
- R11: `irq` is high exactly when (control 2 bit 8 AND transfer-finished) OR (control 2 bit 9 AND write-complete).
- R12: A command write that arrives while a command is in flight is ignored. No second request follows the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register index: 0 control 1, 1 control 2, 2 status |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| shf_req | output | 1 | Command request to the SPI shifter |
| shf_opcode | output | 8 | Flash opcode to transmit |
| shf_bank | output | 2 | Flash bank (chip select) to use |
| shf_rx_bytes | output | 1 | Number of bytes to receive after the opcode (0 or 1) |
| shf_ack | input | 1 | Shifter accepted the request |
| shf_done | input | 1 | Shifter finished the command |
| shf_rxdata | input | 8 | Byte received by the shifter |
| wc_evt | input | 1 | Write-complete event from the programming path |
| wc_bank | input | 2 | Bank that the write-complete event belongs to |
| err_evt | input | 2 | Error events, one per error flag |
| irq | output | 1 | Interrupt request |

## Verification
A command completion from the shifter and a software write to the status register can land on the same clock edge. The completion wants to set transfer-finished, and the write wants to clear the flags. The bench creates this case in two steps. It first sets transfer-finished and write-complete. It then drives `shf_done` in the same cycle as a status write of zero. The expected result is that transfer-finished stays set and write-complete is cleared, which shows both that the set wins and that the clear still applies to the other flag. A second overlap, a new command write while one is in flight, is judged by checking that no further request appears on the shifter.

// File: rtl/fhs_pkg.sv
package fhs_pkg;

    localparam int BYTE_W = 8;

    // flash opcodes
    localparam logic [BYTE_W-1:0] OPC_RDSR = 8'h05;
    localparam logic [BYTE_W-1:0] OPC_WREN = 8'h06;

    // register indexes
    localparam logic [1:0] ADDR_CTRL1 = 2'd0;
    localparam logic [1:0] ADDR_CTRL2 = 2'd1;
    localparam logic [1:0] ADDR_STAT  = 2'd2;

    // control 1 fields
    localparam int C1_SWMODE  = 28;

    // control 2 fields
    localparam int C2_IEN_TF  = 8;
    localparam int C2_IEN_WC  = 9;
    localparam int C2_GO_RDSR = 10;
    localparam int C2_GO_WREN = 11;
    localparam int C2_BANK_LO = 12;

    // status fields
    localparam int ST_TFF     = 8;
    localparam int ST_WCF     = 9;
    localparam int ST_ERR_LO  = 10;
    localparam int ST_WM_LO   = 12;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_e;

    typedef enum logic {
        CMD_RDSR = 1'b0,
        CMD_WREN = 1'b1
    } cmd_e;

endpackage

// File: rtl/fhs_ctrl.sv
module fhs_ctrl
    import fhs_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_c1,
    input  logic              wr_c2,
    input  logic              w_sw,
    input  logic              w_go_rdsr,
    input  logic              w_go_wren,
    input  logic              w_ien_tf,
    input  logic              w_ien_wc,
    input  logic [BANK_W-1:0] w_bank,
    input  logic              seq_busy,
    output logic              sw_mode,
    output logic              ien_tf,
    output logic              ien_wc,
    output logic [BANK_W-1:0] bank_sel,
    output logic              launch,
    output cmd_e              launch_cmd,
    output logic [BANK_W-1:0] launch_bank
);

    typedef struct packed {
        logic              sw;
        logic              ien_tf;
        logic              ien_wc;
        logic [BANK_W-1:0] bank;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_c1) begin
            ctrl_d.sw = w_sw;
        end
        if (wr_c2) begin
            ctrl_d.ien_tf = w_ien_tf;
            ctrl_d.ien_wc = w_ien_wc;
            ctrl_d.bank   = w_bank;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // a command starts only from hardware mode and only when the sequencer is free
    assign launch      = wr_c2 && (w_go_rdsr || w_go_wren) && !ctrl_q.sw && !seq_busy;
    assign launch_cmd  = w_go_rdsr ? CMD_RDSR : CMD_WREN;
    assign launch_bank = w_bank;

    assign sw_mode  = ctrl_q.sw;
    assign ien_tf   = ctrl_q.ien_tf;
    assign ien_wc   = ctrl_q.ien_wc;
    assign bank_sel = ctrl_q.bank;

endmodule

// File: rtl/fhs_seq.sv
module fhs_seq
    import fhs_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  cmd_e              launch_cmd,
    input  logic [BANK_W-1:0] launch_bank,
    input  logic              shf_ack,
    input  logic              shf_done,
    input  logic [BYTE_W-1:0] shf_rxdata,
    output logic              shf_req,
    output logic [BYTE_W-1:0] shf_opcode,
    output logic [BANK_W-1:0] shf_bank,
    output logic              shf_rx_bytes,
    output logic              busy,
    output cmd_e              busy_cmd,
    output logic              cmpl,
    output cmd_e              cmpl_cmd,
    output logic [BANK_W-1:0] cmpl_bank,
    output logic [BYTE_W-1:0] cmpl_byte
);

    typedef struct packed {
        seq_state_e        st;
        cmd_e              cmd;
        logic [BANK_W-1:0] bank;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            SQ_IDLE: begin
                if (launch) begin
                    seq_d.st   = SQ_ISSUE;
                    seq_d.cmd  = launch_cmd;
                    seq_d.bank = launch_bank;
                end
            end
            SQ_ISSUE: begin
                if (shf_ack) begin
                    seq_d.st = SQ_WAIT;
                end
            end
            SQ_WAIT: begin
                if (shf_done) begin
                    seq_d.st = SQ_IDLE;
                end
            end
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SQ_IDLE, cmd: CMD_RDSR, bank: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign shf_req      = (seq_q.st == SQ_ISSUE);
    assign shf_opcode   = (seq_q.cmd == CMD_RDSR) ? OPC_RDSR : OPC_WREN;
    assign shf_bank     = seq_q.bank;
    assign shf_rx_bytes = (seq_q.cmd == CMD_RDSR);

    assign busy      = (seq_q.st != SQ_IDLE);
    assign busy_cmd  = seq_q.cmd;
    assign cmpl      = (seq_q.st == SQ_WAIT) && shf_done;
    assign cmpl_cmd  = seq_q.cmd;
    assign cmpl_bank = seq_q.bank;
    assign cmpl_byte = shf_rxdata;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        shf_req && !shf_ack |=> shf_req); // R2
    AST_REQ_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        shf_req && !shf_ack |=> $stable(shf_opcode) && $stable(shf_bank)); // R2
    AST_WREN_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
        shf_req && (shf_opcode == OPC_WREN) |-> !shf_rx_bytes); // R3
    AST_NO_LAUNCH_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !launch); // R12

endmodule

// File: rtl/fhs_status.sv
module fhs_status
    import fhs_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_st,
    input  logic [3:0]           w_keep,
    input  logic                 cmpl,
    input  cmd_e                 cmpl_cmd,
    input  logic [BANK_W-1:0]    cmpl_bank,
    input  logic [BYTE_W-1:0]    cmpl_byte,
    input  logic                 wc_evt,
    input  logic [BANK_W-1:0]    wc_bank,
    input  logic [1:0]           err_evt,
    output logic [BYTE_W-1:0]    flash_byte,
    output logic                 tff,
    output logic                 wcf,
    output logic [1:0]           err,
    output logic [NUM_BANKS-1:0] wm
);

    typedef struct packed {
        logic [BYTE_W-1:0]    fbyte;
        logic                 tff;
        logic                 wcf;
        logic [1:0]           err;
        logic [NUM_BANKS-1:0] wm;
    } stat_t;

    stat_t stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        // software clear: a zero in the written word drops the flag
        if (wr_st) begin
            stat_d.tff = stat_q.tff & w_keep[0];
            stat_d.wcf = stat_q.wcf & w_keep[1];
            stat_d.err = stat_q.err & w_keep[3:2];
        end
        // hardware sets come after, so they win over a clear in the same cycle
        if (cmpl) begin
            stat_d.tff = 1'b1;
            if (cmpl_cmd == CMD_RDSR) begin
                stat_d.fbyte           = cmpl_byte;
                stat_d.wm[cmpl_bank]   = cmpl_byte[1];
            end
        end
        if (wc_evt) begin
            stat_d.wcf         = 1'b1;
            stat_d.wm[wc_bank] = 1'b0;
        end
        stat_d.err = stat_d.err | err_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign flash_byte = stat_q.fbyte;
    assign tff        = stat_q.tff;
    assign wcf        = stat_q.wcf;
    assign err        = stat_q.err;
    assign wm         = stat_q.wm;

    AST_TFF_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl |=> tff); // R7
    AST_TFF_ONLY_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tff) |-> $past(cmpl)); // R7
    AST_WC_SETS_AND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wc_evt |=> wcf && !wm[$past(wc_bank)]); // R8

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_wm_chk
        AST_WM_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
            cmpl && (cmpl_cmd == CMD_RDSR) && (cmpl_bank == BANK_W'(g))
            && !(wc_evt && (wc_bank == BANK_W'(g)))
            |=> wm[g] == $past(cmpl_byte[1])); // R6
    end

endmodule

// File: rtl/fhs_top.sv
module fhs_top
    import fhs_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              shf_req,
    output logic [7:0]        shf_opcode,
    output logic [BANK_W-1:0] shf_bank,
    output logic              shf_rx_bytes,
    input  logic              shf_ack,
    input  logic              shf_done,
    input  logic [7:0]        shf_rxdata,
    input  logic              wc_evt,
    input  logic [BANK_W-1:0] wc_bank,
    input  logic [1:0]        err_evt,
    output logic              irq
);

    logic              wr_c1, wr_c2, wr_st;
    logic              sw_mode, ien_tf, ien_wc;
    logic [BANK_W-1:0] bank_sel;
    logic              launch;
    cmd_e              launch_cmd;
    logic [BANK_W-1:0] launch_bank;
    logic              busy;
    cmd_e              busy_cmd;
    logic              cmpl;
    cmd_e              cmpl_cmd;
    logic [BANK_W-1:0] cmpl_bank;
    logic [7:0]        cmpl_byte;
    logic [7:0]        flash_byte;
    logic              tff, wcf;
    logic [1:0]        err;
    logic [NUM_BANKS-1:0] wm;

    assign wr_c1 = bus_wr && (bus_addr == ADDR_CTRL1);
    assign wr_c2 = bus_wr && (bus_addr == ADDR_CTRL2);
    assign wr_st = bus_wr && (bus_addr == ADDR_STAT);

    fhs_ctrl #(.BANK_W(BANK_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_c1       (wr_c1),
        .wr_c2       (wr_c2),
        .w_sw        (bus_wdata[C1_SWMODE]),
        .w_go_rdsr   (bus_wdata[C2_GO_RDSR]),
        .w_go_wren   (bus_wdata[C2_GO_WREN]),
        .w_ien_tf    (bus_wdata[C2_IEN_TF]),
        .w_ien_wc    (bus_wdata[C2_IEN_WC]),
        .w_bank      (bus_wdata[C2_BANK_LO +: BANK_W]),
        .seq_busy    (busy),
        .sw_mode     (sw_mode),
        .ien_tf      (ien_tf),
        .ien_wc      (ien_wc),
        .bank_sel    (bank_sel),
        .launch      (launch),
        .launch_cmd  (launch_cmd),
        .launch_bank (launch_bank)
    );

    fhs_seq #(.BANK_W(BANK_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (launch),
        .launch_cmd   (launch_cmd),
        .launch_bank  (launch_bank),
        .shf_ack      (shf_ack),
        .shf_done     (shf_done),
        .shf_rxdata   (shf_rxdata),
        .shf_req      (shf_req),
        .shf_opcode   (shf_opcode),
        .shf_bank     (shf_bank),
        .shf_rx_bytes (shf_rx_bytes),
        .busy         (busy),
        .busy_cmd     (busy_cmd),
        .cmpl         (cmpl),
        .cmpl_cmd     (cmpl_cmd),
        .cmpl_bank    (cmpl_bank),
        .cmpl_byte    (cmpl_byte)
    );

    fhs_status #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_st      (wr_st),
        .w_keep     (bus_wdata[ST_TFF +: 4]),
        .cmpl       (cmpl),
        .cmpl_cmd   (cmpl_cmd),
        .cmpl_bank  (cmpl_bank),
        .cmpl_byte  (cmpl_byte),
        .wc_evt     (wc_evt),
        .wc_bank    (wc_bank),
        .err_evt    (err_evt),
        .flash_byte (flash_byte),
        .tff        (tff),
        .wcf        (wcf),
        .err        (err),
        .wm         (wm)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL1: bus_rdata[C1_SWMODE] = sw_mode;
            ADDR_CTRL2: begin
                bus_rdata[C2_IEN_TF]               = ien_tf;
                bus_rdata[C2_IEN_WC]               = ien_wc;
                bus_rdata[C2_GO_RDSR]              = busy && (busy_cmd == CMD_RDSR);
                bus_rdata[C2_GO_WREN]              = busy && (busy_cmd == CMD_WREN);
                bus_rdata[C2_BANK_LO +: BANK_W]    = bank_sel;
            end
            ADDR_STAT: begin
                bus_rdata[7:0]                     = flash_byte;
                bus_rdata[ST_TFF]                  = tff;
                bus_rdata[ST_WCF]                  = wcf;
                bus_rdata[ST_ERR_LO +: 2]          = err;
                bus_rdata[ST_WM_LO +: NUM_BANKS]   = wm;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign irq = (ien_tf && tff) || (ien_wc && wcf);

    AST_SW_MODE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_mode && !shf_req |=> !shf_req); // R10
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> tff || wcf); // R11

endmodule

// File: tb/fhs_top_tb_top.sv
module fhs_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        shf_req;
    logic [7:0]  shf_opcode;
    logic [1:0]  shf_bank;
    logic        shf_rx_bytes;
    logic        shf_ack = 1'b0;
    logic        shf_done = 1'b0;
    logic [7:0]  shf_rxdata = '0;
    logic        wc_evt = 1'b0;
    logic [1:0]  wc_bank = '0;
    logic [1:0]  err_evt = '0;
    logic        irq;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;   // 250 MHz

    fhs_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .shf_req      (shf_req),
        .shf_opcode   (shf_opcode),
        .shf_bank     (shf_bank),
        .shf_rx_bytes (shf_rx_bytes),
        .shf_ack      (shf_ack),
        .shf_done     (shf_done),
        .shf_rxdata   (shf_rxdata),
        .wc_evt       (wc_evt),
        .wc_bank      (wc_bank),
        .err_evt      (err_evt),
        .irq          (irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic pulse_wc(input logic [1:0] b);
        @(negedge clk);
        wc_evt = 1'b1; wc_bank = b;
        @(negedge clk);
        wc_evt = 1'b0;
    endtask

    // shifter model: wait for a request, hold off ack, then finish with a byte
    task automatic serve(input int ack_wait, input logic [7:0] rx,
                         output logic [7:0] op, output logic [1:0] bk,
                         output logic rxn, output logic seen, output logic held);
        seen = 1'b0; held = 1'b1; op = '0; bk = '0; rxn = 1'b0;
        for (int i = 0; i < 50 && !shf_req; i++) @(negedge clk);
        if (!shf_req) return;
        seen = 1'b1;
        op = shf_opcode; bk = shf_bank; rxn = shf_rx_bytes;
        for (int i = 0; i < ack_wait; i++) begin
            @(negedge clk);
            if (!shf_req || shf_opcode !== op || shf_bank !== bk) held = 1'b0;
        end
        shf_ack = 1'b1;
        @(negedge clk);
        shf_ack = 1'b0;
        @(negedge clk);
        shf_done = 1'b1; shf_rxdata = rx;
        @(negedge clk);
        shf_done = 1'b0; shf_rxdata = '0;
    endtask

    task automatic count_reqs(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (shf_req) n++;
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        read_reg(2'd0, v); chk("R1", "ctrl1", v, 32'h0);
        read_reg(2'd1, v); chk("R1", "ctrl2", v, 32'h0);
        read_reg(2'd2, v); chk("R1", "status", v, 32'h0);
        chk("R1", "shf_req", {31'b0, shf_req}, 32'h0);
        chk("R1", "irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_read_status;
        logic [7:0] op; logic [1:0] bk; logic rxn, seen, held; logic [31:0] v;
        bus_write(2'd1, (32'd1 << 12) | (32'd1 << 10));
        chk("R2", "req next cycle", {31'b0, shf_req}, 32'h1);
        read_reg(2'd1, v); chk("R2", "busy readback", v & 32'h0C00, 32'h0400);
        serve(3, 8'h03, op, bk, rxn, seen, held);
        chk("R2", "seen", {31'b0, seen}, 32'h1);
        chk("R2", "held until ack", {31'b0, held}, 32'h1);
        chk("R2", "opcode", {24'b0, op}, 32'h05);
        chk("R2", "bank", {30'b0, bk}, 32'h1);
        chk("R2", "rx bytes", {31'b0, rxn}, 32'h1);
        read_reg(2'd2, v);
        chk("R5", "flash byte", v & 32'hFF, 32'h03);
        chk("R7", "tff", (v >> 8) & 1, 32'h1);
        chk("R6", "wm flags", (v >> 12) & 32'hF, 32'h2);
    endtask

    task automatic t_write_enable;
        logic [7:0] op; logic [1:0] bk; logic rxn, seen, held; logic [31:0] v;
        bus_write(2'd2, 32'h0);
        read_reg(2'd2, v); chk("R9", "tff cleared", (v >> 8) & 1, 32'h0);
        bus_write(2'd1, (32'd2 << 12) | (32'd1 << 11));
        serve(0, 8'hA5, op, bk, rxn, seen, held);
        chk("R3", "opcode", {24'b0, op}, 32'h06);
        chk("R3", "bank", {30'b0, bk}, 32'h2);
        chk("R3", "rx bytes", {31'b0, rxn}, 32'h0);
        read_reg(2'd2, v);
        chk("R7", "tff after wren", (v >> 8) & 1, 32'h1);
        chk("R5", "byte kept on wren", v & 32'hFF, 32'h03);
        chk("R6", "wm kept on wren", (v >> 12) & 32'hF, 32'h2);
    endtask

    task automatic t_both_bits;
        logic [7:0] op; logic [1:0] bk; logic rxn, seen, held; int n;
        logic [31:0] v;
        bus_write(2'd1, (32'd3 << 12) | (32'd3 << 10));
        serve(1, 8'h02, op, bk, rxn, seen, held);
        chk("R4", "read-status first", {24'b0, op}, 32'h05);
        count_reqs(10, n);
        chk("R4", "single command", n, 0);
        read_reg(2'd2, v);
        chk("R6", "wm bank3 set, bank1 kept", (v >> 12) & 32'hF, 32'hA);
    endtask

    task automatic t_busy;
        logic [7:0] op; logic [1:0] bk; logic rxn, seen, held; int n;
        bus_write(2'd1, (32'd0 << 12) | (32'd1 << 11));
        bus_write(2'd1, (32'd3 << 12) | (32'd1 << 10));
        serve(0, 8'h00, op, bk, rxn, seen, held);
        chk("R12", "first command kept", {24'b0, op}, 32'h06);
        chk("R12", "first bank kept", {30'b0, bk}, 32'h0);
        count_reqs(10, n);
        chk("R12", "no second request", n, 0);
    endtask

    task automatic t_sw_mode;
        logic [7:0] op; logic [1:0] bk; logic rxn, seen, held; int n;
        logic [31:0] v;
        bus_write(2'd0, 32'h1000_0000);
        read_reg(2'd0, v); chk("R10", "sw bit", v, 32'h1000_0000);
        bus_write(2'd1, (32'd1 << 12) | (32'd1 << 10));
        count_reqs(10, n);
        chk("R10", "no request in sw mode", n, 0);
        bus_write(2'd0, 32'h0);
        bus_write(2'd1, (32'd1 << 12) | (32'd1 << 10));
        serve(0, 8'h01, op, bk, rxn, seen, held);
        chk("R10", "request after leaving sw mode", {31'b0, seen}, 32'h1);
        read_reg(2'd2, v);
        chk("R5", "wip byte", v & 32'hFF, 32'h01);
        chk("R6", "wm bank1 cleared by read", (v >> 12) & 32'hF, 32'h8);
    endtask

    task automatic t_flags;
        logic [31:0] v;
        bus_write(2'd2, 32'h0);
        pulse_wc(2'd3);
        read_reg(2'd2, v);
        chk("R8", "wcf set", (v >> 9) & 1, 32'h1);
        chk("R8", "wm bank3 cleared", (v >> 12) & 32'hF, 32'h0);
        @(negedge clk); err_evt = 2'b01;
        @(negedge clk); err_evt = 2'b10;
        @(negedge clk); err_evt = 2'b00;
        read_reg(2'd2, v);
        chk("R8", "errors", (v >> 10) & 3, 32'h3);
        bus_write(2'd2, 32'h0000_0F00);
        read_reg(2'd2, v);
        chk("R9", "write ones keeps", (v >> 8) & 32'hF, 32'hE);
        bus_write(2'd2, 32'h0000_0400);
        read_reg(2'd2, v);
        chk("R9", "partial clear", (v >> 8) & 32'hF, 32'h4);
    endtask

    task automatic t_irq;
        logic [7:0] op; logic [1:0] bk; logic rxn, seen, held;
        bus_write(2'd2, 32'h0);
        bus_write(2'd1, 32'd1 << 9);
        chk("R11", "irq idle", {31'b0, irq}, 32'h0);
        pulse_wc(2'd0);
        chk("R11", "irq on wcf", {31'b0, irq}, 32'h1);
        bus_write(2'd2, 32'h0);
        chk("R11", "irq after clear", {31'b0, irq}, 32'h0);
        bus_write(2'd1, (32'd1 << 8) | (32'd1 << 10));
        serve(0, 8'h00, op, bk, rxn, seen, held);
        chk("R11", "irq on tff", {31'b0, irq}, 32'h1);
        bus_write(2'd1, 32'h0);
        chk("R11", "irq masked", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] v; int w;
        pulse_wc(2'd1);
        read_reg(2'd2, v);
        chk("R9", "pre tff and wcf", (v >> 8) & 3, 32'h3);
        bus_write(2'd1, 32'd1 << 11);
        w = 0;
        while (!shf_req && w < 50) begin @(negedge clk); w++; end
        shf_ack = 1'b1;
        @(negedge clk);
        shf_ack = 1'b0;
        @(negedge clk);
        shf_done = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h0;
        @(negedge clk);
        shf_done = 1'b0; bus_wr = 1'b0;
        read_reg(2'd2, v);
        chk("R9", "set wins over clear", (v >> 8) & 1, 32'h1);
        chk("R9", "clear still applied", (v >> 9) & 1, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_status();
        t_write_enable();
        t_both_bits();
        t_busy();
        t_sw_mode();
        t_flags();
        t_irq();
        t_collide();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule